// File: doc/BRIEF.md
# SMBus Alert Response Slave

This block is the alert side of an SMBus slave. When logic inside the device raises an alert request, the block pulls the shared open-drain alert line low and keeps it low until a master services the alert. It services the alert in this way. The master issues START. It then sends the broadcast alert response address 0001100 with the read bit set, which is the byte 0x19. The block acknowledges that byte. It then returns its own 7-bit address, followed by an eighth bit whose value is fixed by a parameter.

Several slaves may answer at once. Arbitration uses the wired-AND behaviour of the bus. On every bit the block releases the line for a 1, and it compares the released bit with the level it reads while SCL is high. If it reads a 0 where it sent a 1, it has lost. It then stops driving for the rest of the byte and keeps its alert pending. A slave that sends its whole byte has won, and it drops its alert.

The SCL and SDA inputs are assumed to be already synchronised to `clk`. Both outputs are pull-down enables for external open-drain pads. Command and data traffic addressed to the device's own address is handled elsewhere. Every interface of this block is a plain control pin, so no valid/ready handshake is used and no back-pressure exists.

Top module: `smbus_ara_slave`

## Requirements
- R1: While reset is asserted, and on leaving reset, `sda_pull` and `alert_pull` are both 0 (bus released, no alert).
- R2: A one-cycle `alert_req` pulse while no alert response is in progress sets `alert_pull` to 1 from the next cycle, and it stays 1 until the alert is won.
- R3: After START, the block receives 8 bits MSB first, one bit on each SCL rising edge. If the byte equals 0x19 and an alert is pending, the block sets `sda_pull` = 1 during the following acknowledge clock.
- R4: Any other first byte (wrong address, or the write bit 0x18), or the byte 0x19 while no alert is pending, gets no acknowledge. `sda_pull` stays 0 until the next START.
- R5: After its acknowledge, the block sends the byte {`dev_addr`[6:0], EIGHTH_BIT} MSB first. Each bit is placed after an SCL falling edge, and `sda_pull` = 1 drives a 0 while `sda_pull` = 0 releases a 1.
- R6: If the block releases a 1 and samples SDA = 0 at an SCL rising edge, it loses arbitration. It releases SDA for the rest of the byte, and `alert_pull` stays 1.
- R7: If all 8 bits are sent without a loss, the block clears `alert_pull` at the SCL falling edge after the eighth bit, and it releases SDA for the master's ACK/NACK bit.
- R8: An `alert_req` that arrives between the block's acknowledge and the STOP that ends that transaction is held. It sets `alert_pull` again once that STOP is seen.
- R9: `sda_pull` changes value only while SCL is low.
- R10: START, including a repeated START in the middle of a byte, restarts address reception from bit 0. STOP returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Synchronised SCL level |
| sda | input | 1 | Synchronised SDA level (bus value, including this block's own pull) |
| alert_req | input | 1 | Internal alert request, one-cycle pulse |
| dev_addr | input | 7 | This device's 7-bit slave address |
| sda_pull | output | 1 | 1 = pull SDA low |
| alert_pull | output | 1 | 1 = pull the alert line low |

## Verification
The assertions assume the following about the inputs. SDA changes while SCL is high only to form START or STOP. Each SCL phase lasts several `clk` cycles. `alert_req` is a short pulse. The bench produces SCL and SDA from bit tasks that change the master's SDA only in the middle of the SCL low phase. It holds each phase for at least eight clocks, and it forms the bus level as the wired-AND of the master, a modelled competing slave and the block's own pull. The competing slave also arbitrates bit by bit, so the value the bench expects on the bus is the smaller of the two answer bytes.

// File: rtl/smbus_ara_pkg.sv
package smbus_ara_pkg;
  localparam int unsigned ARA_ADDR_W = 7;
  localparam int unsigned ARA_BYTE_W = ARA_ADDR_W + 1;
  localparam logic [ARA_ADDR_W-1:0] ARA_ADDR = 7'b0001100;
  localparam logic [ARA_BYTE_W-1:0] ARA_RD_BYTE = {ARA_ADDR, 1'b1};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_SEND,
    ST_HOLD
  } ara_state_t;
endpackage

// File: rtl/smbus_ara_cond.sv
module smbus_ara_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign start_det = scl & scl_q & sda_q & ~sda;
  assign stop_det  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/smbus_ara_engine.sv
module smbus_ara_engine
  import smbus_ara_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_rise,
  input  logic                  scl_fall,
  input  logic                  start_det,
  input  logic                  stop_det,
  input  logic                  sda,
  input  logic                  alert_pending,
  input  logic [ARA_BYTE_W-1:0] tx_byte,
  output logic                  sda_pull,
  output logic                  resp_start,
  output logic                  won,
  output logic                  lost
);
  localparam int unsigned CW = $clog2(ARA_BYTE_W + 1);
  localparam logic [CW-1:0] LAST = CW'(ARA_BYTE_W);

  ara_state_t            state;
  logic [CW-1:0]         cnt;
  logic [ARA_BYTE_W-1:0] rx_sh;
  logic [ARA_BYTE_W-1:0] tx_sh;
  logic                  matched;
  logic [ARA_BYTE_W-1:0] rx_next;

  assign rx_next = {rx_sh[ARA_BYTE_W-2:0], sda};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      matched    <= 1'b0;
      sda_pull   <= 1'b0;
      resp_start <= 1'b0;
      won        <= 1'b0;
      lost       <= 1'b0;
    end else begin
      resp_start <= 1'b0;
      won        <= 1'b0;
      if (start_det) begin
        state    <= ST_ADDR;
        cnt      <= '0;
        matched  <= 1'b0;
        sda_pull <= 1'b0;
        lost     <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
        lost     <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise && cnt != LAST) begin
              rx_sh <= rx_next;
              cnt   <= cnt + 1'b1;
              if (cnt == LAST - 1'b1)
                matched <= (rx_next == ARA_RD_BYTE) && alert_pending;
            end else if (scl_fall && cnt == LAST) begin
              if (matched) begin
                state      <= ST_ACK;
                sda_pull   <= 1'b1;
                resp_start <= 1'b1;
              end else begin
                state <= ST_HOLD;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state    <= ST_SEND;
              cnt      <= '0;
              sda_pull <= ~tx_byte[ARA_BYTE_W-1];
              tx_sh    <= {tx_byte[ARA_BYTE_W-2:0], 1'b0};
            end
          end
          ST_SEND: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
              if (!sda_pull && !sda) begin
                lost  <= 1'b1;
                state <= ST_HOLD;
              end
            end else if (scl_fall) begin
              if (cnt == LAST) begin
                won      <= 1'b1;
                sda_pull <= 1'b0;
                state    <= ST_HOLD;
              end else begin
                sda_pull <= ~tx_sh[ARA_BYTE_W-1];
                tx_sh    <= {tx_sh[ARA_BYTE_W-2:0], 1'b0};
              end
            end
          end
          default: sda_pull <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/smbus_ara_alert.sv
module smbus_ara_alert (
  input  logic clk,
  input  logic rst_n,
  input  logic alert_req,
  input  logic resp_start,
  input  logic won,
  input  logic stop_det,
  output logic pending,
  output logic deferred,
  output logic resp_active
);
  logic defer_now;

  assign defer_now = alert_req && (resp_active || resp_start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending     <= 1'b0;
      deferred    <= 1'b0;
      resp_active <= 1'b0;
    end else begin
      if (resp_start) resp_active <= 1'b1;
      if (won) pending <= 1'b0;
      if (alert_req && !defer_now) pending <= 1'b1;
      if (defer_now) deferred <= 1'b1;
      if (stop_det) begin
        resp_active <= 1'b0;
        deferred    <= 1'b0;
        if (deferred || defer_now) pending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/smbus_ara_slave.sv
module smbus_ara_slave
  import smbus_ara_pkg::*;
#(
  parameter logic EIGHTH_BIT = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl,
  input  logic                  sda,
  input  logic                  alert_req,
  input  logic [ARA_ADDR_W-1:0] dev_addr,
  output logic                  sda_pull,
  output logic                  alert_pull
);
  logic scl_rise, scl_fall, start_det, stop_det;
  logic resp_start, won, lost;
  logic pending, deferred, resp_active;
  logic [ARA_BYTE_W-1:0] tx_byte;

  assign tx_byte = {dev_addr, EIGHTH_BIT};

  smbus_ara_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smbus_ara_engine u_eng (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda(sda),
    .alert_pending(pending), .tx_byte(tx_byte), .sda_pull(sda_pull),
    .resp_start(resp_start), .won(won), .lost(lost)
  );

  smbus_ara_alert u_alert (
    .clk(clk), .rst_n(rst_n), .alert_req(alert_req),
    .resp_start(resp_start), .won(won), .stop_det(stop_det),
    .pending(pending), .deferred(deferred), .resp_active(resp_active)
  );

  assign alert_pull = pending;
endmodule

// File: rtl/smbus_ara_chk.sv
module smbus_ara_chk (
  input logic clk,
  input logic rst_n,
  input logic scl,
  input logic alert_req,
  input logic sda_pull,
  input logic alert_pull,
  input logic stop_det,
  input logic resp_start,
  input logic resp_active,
  input logic deferred,
  input logic lost
);
  // R1: outputs released during reset
  always @(posedge clk)
    if (!rst_n) a_r1_reset_released: assert (!sda_pull && !alert_pull);

  a_r2_req_raises_alert: assert property (@(posedge clk) disable iff (!rst_n)
    alert_req && !resp_active && !resp_start |=> alert_pull);

  a_r6_lost_keeps_alert: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> alert_pull);

  a_r7_release_on_win: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_pull) |-> !sda_pull);

  a_r8_deferred_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det && deferred |=> alert_pull);

  a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !scl);
endmodule

bind smbus_ara_slave smbus_ara_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl(scl), .alert_req(alert_req),
  .sda_pull(sda_pull), .alert_pull(alert_pull), .stop_det(stop_det),
  .resp_start(resp_start), .resp_active(resp_active),
  .deferred(deferred), .lost(lost)
);

// File: tb/sim_smbus_ara_slave.sv
`timescale 1ns/1ps
module sim_smbus_ara_slave;
  localparam logic [6:0] DEV = 7'h2A;
  localparam logic       EB  = 1'b0;
  localparam logic [7:0] DUT_BYTE = {DEV, EB};
  // {first byte, alert pending, competitor answer byte (FF = absent)}
  localparam int NV = 7;
  localparam logic [16:0] VEC [NV] = '{
    {8'h19, 1'b1, 8'hFF},
    {8'h19, 1'b0, 8'hFF},
    {8'h55, 1'b1, 8'hFF},
    {8'h19, 1'b1, 8'h30},
    {8'h19, 1'b1, 8'h7E},
    {8'h18, 1'b1, 8'hFF},
    {8'h19, 1'b1, 8'h55}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1, c_sda = 1'b1;
  logic alert_req = 1'b0;
  logic sda_pull, alert_pull, sda_bus;
  int checks = 0, errors = 0, r9_viol = 0;
  logic done = 1'b0;
  logic prev_pull = 1'b0;

  assign sda_bus = m_sda & c_sda & ~sda_pull;
  always #2 clk = ~clk;

  smbus_ara_slave #(.EIGHTH_BIT(EB)) u0 (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda_bus),
    .alert_req(alert_req), .dev_addr(DEV),
    .sda_pull(sda_pull), .alert_pull(alert_pull)
  );

  always @(negedge clk) begin
    if (rst_n && scl && sda_pull !== prev_pull) r9_viol++;
    prev_pull <= sda_pull;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1; c_sda = 1'b1; alert_req = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(2);
  endtask

  task automatic pulse_req();
    alert_req = 1'b1; tick(1); alert_req = 1'b0; tick(1);
  endtask

  task automatic do_start();
    tick(4); m_sda = 1'b1; c_sda = 1'b1; tick(4);
    scl = 1'b1; tick(8); m_sda = 1'b0; tick(8); scl = 1'b0;
  endtask

  task automatic do_stop();
    tick(4); m_sda = 1'b0; c_sda = 1'b1; tick(4);
    scl = 1'b1; tick(8); m_sda = 1'b1; tick(8);
  endtask

  task automatic clk_bit(input logic mb, input logic cb, output logic seen);
    tick(4); m_sda = mb; c_sda = cb; tick(4);
    scl = 1'b1; tick(4); seen = sda_bus; tick(4); scl = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b1, s);
  endtask

  task automatic read_byte(input logic [7:0] other, output logic [7:0] got);
    logic lost_c, cb, s;
    lost_c = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      cb = lost_c ? 1'b1 : other[i];
      clk_bit(1'b1, cb, s);
      if (cb && !s) lost_c = 1'b1;
      got[i] = s;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic s;
    logic [7:0] got;
    // R1: reset state
    tick(2);
    chk("R1 sda_pull in reset", {7'd0, sda_pull}, 8'd0);
    chk("R1 alert_pull in reset", {7'd0, alert_pull}, 8'd0);
    rst_n = 1'b1; tick(2);
    chk("R1 alert_pull after reset", {7'd0, alert_pull}, 8'd0);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] fb, oth, exp_byte;
      logic pend, ack_exp, win;
      fb = VEC[v][16:9]; pend = VEC[v][8]; oth = VEC[v][7:0];
      ack_exp = (fb == 8'h19) && pend;
      win = DUT_BYTE < oth;
      exp_byte = win ? DUT_BYTE : oth;
      do_reset();
      if (pend) pulse_req();
      chk("R2 alert after request", {7'd0, alert_pull}, {7'd0, pend});
      do_start();
      write_byte(fb);
      clk_bit(1'b1, 1'b1, s);
      chk(ack_exp ? "R3 ack to alert response" : "R4 no ack", {7'd0, ~s}, {7'd0, ack_exp});
      if (ack_exp) begin
        read_byte(oth, got);
        chk(win ? "R5 returned address byte" : "R6 bus carries lower address", got, exp_byte);
        tick(4);
        chk(win ? "R7 alert released on win" : "R6 alert kept on loss",
            {7'd0, alert_pull}, {7'd0, !win});
        clk_bit(1'b1, 1'b1, s);
        chk("R7 SDA released for master NACK", {7'd0, s}, 8'd1);
      end else begin
        read_byte(8'hFF, got);
        chk("R4 SDA untouched after no ack", got, 8'hFF);
      end
      do_stop();
      chk("R6 R7 alert after STOP", {7'd0, alert_pull}, {7'd0, pend && !(ack_exp && win)});
    end

    // R8: request during response is held until STOP
    do_reset();
    pulse_req();
    do_start();
    write_byte(8'h19);
    clk_bit(1'b1, 1'b1, s);
    chk("R8 ack before deferred request", {7'd0, ~s}, 8'd1);
    pulse_req();
    read_byte(8'hFF, got);
    chk("R8 byte sent", got, DUT_BYTE);
    tick(4);
    chk("R8 alert low before STOP", {7'd0, alert_pull}, 8'd0);
    clk_bit(1'b1, 1'b1, s);
    do_stop();
    chk("R8 alert re-asserted after STOP", {7'd0, alert_pull}, 8'd1);

    // R10: repeated START mid-byte restarts address reception
    do_reset();
    pulse_req();
    do_start();
    clk_bit(1'b0, 1'b1, s);
    clk_bit(1'b0, 1'b1, s);
    clk_bit(1'b1, 1'b1, s);
    do_start();
    write_byte(8'h19);
    clk_bit(1'b1, 1'b1, s);
    chk("R10 ack after repeated START", {7'd0, ~s}, 8'd1);
    read_byte(8'hFF, got);
    chk("R10 byte after repeated START", got, DUT_BYTE);
    clk_bit(1'b1, 1'b1, s);
    do_stop();

    chk("R9 sda_pull changes while SCL high", r9_viol[7:0], 8'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule